// File: doc/BRIEF.md
# Event Header Framer

The block builds the four-word header that opens every acquired event and sends it as 32-bit words on a valid/ready stream. It keeps a 24-bit event counter and a free-running 48-bit trigger time tag. When a trigger is accepted as an event, it captures these values together with the trigger sources, the channel mask, the configuration bits and the payload length. It then presents the four words one after another, and holds each word until the sink takes it.

A payload formatter downstream places the sample data behind the header. The first header word carries the total event length. That length is the externally supplied payload word count plus the four header words. The second word has a 16-bit field whose meaning depends on a 2-bit mode. The field reads as zeros, as a map of which triggers fired, or as the upper part of the extended time tag. The event counter advances either on every trigger or only on accepted ones.

Top module: `evt_header_framer`

## Requirements
- R1: After an accepted trigger, out_valid rises on the next cycle and the four header words come out in order W1, W2, W3, W4, one per cycle in which out_valid and out_ready are both high. While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R2: W1 = {4'b1010, (payload_len + 4) mod 2^28}.
- R3: W2 bit 26 is 1 if hw_fault was high in the accept cycle, or in any cycle since the last W4 handshake (or since reset).
- R4: W2 bit 24 equals cfg_zs_en, W2 bits[3:0] equal ch_mask, and W2 bits 31:27, 25 and 7:4 are zero.
- R5: W2 bits[23:8] depend on cfg_mode:
  - 00 or 11: all zero.
  - 01: bit 18 is the software trigger, bit 17 is the external trigger, bits[11:8] are trig_self[3:0], and every other bit of the field is zero.
  - 10: bits[47:32] of the captured time tag.
- R6: W3 = {8'h00, C}, where C is the event counter value before the increment for this trigger. With cfg_count_all = 1 the counter advances in every cycle that has at least one trigger input high. With cfg_count_all = 0 it advances only on accepted triggers.
- R7: The event counter wraps modulo 2^24.
- R8: The time tag starts at TAG_INIT after reset and increases by one every cycle. The tag captured is the value held in the accept cycle. With cfg_mode = 10, W4 holds tag bits[31:0]. Otherwise W4 = {R, tag[30:0]}, where R is the rollover flag of R9.
- R9: The rollover flag is set when the low 31 bits of the time tag wrap to zero. It clears on the W4 handshake, and a wrap in that same cycle wins over the clear. The value captured into a header reports whether a wrap happened between the last W4 handshake (or reset) and the accept cycle.
- R10: evt_accept is ignored while a header is being sent, and also in a cycle with no trigger input high. Header contents are fixed at the accept and do not follow later input changes.
- R11: During and right after reset, out_valid is 0 and the event counter equals CNT_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_sw | input | 1 | Software trigger pulse |
| trig_ext | input | 1 | External trigger pulse |
| trig_self | input | 4 | Per-channel self-trigger pulses |
| evt_accept | input | 1 | Marks this cycle's trigger as an event |
| hw_fault | input | 1 | Hardware fault report |
| ch_mask | input | 4 | Participating channel mask |
| payload_len | input | 28 | Payload length in 32-bit words |
| cfg_mode | input | 2 | Selects the W2 [23:8] field content |
| cfg_count_all | input | 1 | 1: count all triggers, 0: count accepted only |
| cfg_zs_en | input | 1 | Zero-suppression enable, reported in W2 |
| out_valid | output | 1 | Header word valid |
| out_ready | input | 1 | Sink accepts the current word |
| out_data | output | 32 | Header word |

## Verification
The bench starts the time tag just below a 31-bit wrap and then accepts a trigger. A design that misplaces the wrap detection, or clears the flag at the wrong moment, would report a missing or stale rollover bit in W4. The counter starts near 2^24, so a counter that saturates or overruns would corrupt W3. Backpressure and accepts that arrive while a header is in flight are mixed throughout: a framer that re-latches its inputs would hand over words from a different event, and one that skips the hold would drop or repeat words. The bench also sends an accept with no trigger. A payload length near 2^28 checks that the size field wraps rather than spilling into the marker.

// File: rtl/evt_header_framer.sv
module evt_header_framer #(
  parameter logic [47:0] TAG_INIT = 48'd0,
  parameter logic [23:0] CNT_INIT = 24'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig_sw,
  input  logic        trig_ext,
  input  logic [3:0]  trig_self,
  input  logic        evt_accept,
  input  logic        hw_fault,
  input  logic [3:0]  ch_mask,
  input  logic [27:0] payload_len,
  input  logic [1:0]  cfg_mode,
  input  logic        cfg_count_all,
  input  logic        cfg_zs_en,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data
);
  localparam logic [3:0]  MARKER  = 4'b1010;
  localparam logic [27:0] HDR_LEN = 28'd4;

  logic [47:0] tag, tag_q;
  logic [23:0] cnt, cnt_q;
  logic [27:0] size_q;
  logic [5:0]  src_q;
  logic [3:0]  mask_q;
  logic [1:0]  mode_q, wcnt;
  logic        busy, roll_q, flt_q, roll_lat, fail_q, zs_q;
  logic [15:0] field;
  logic [31:0] w4;

  wire any_trig = trig_sw | trig_ext | (|trig_self);
  wire take     = evt_accept & any_trig & ~busy;
  wire last_hs  = busy & out_ready & (wcnt == 2'd3);
  wire tag_wrap = &tag[30:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag    <= TAG_INIT;
      roll_q <= 1'b0;
      flt_q  <= 1'b0;
      cnt    <= CNT_INIT;
    end else begin
      tag <= tag + 48'd1;
      if (tag_wrap)     roll_q <= 1'b1;
      else if (last_hs) roll_q <= 1'b0;
      if (hw_fault)     flt_q <= 1'b1;
      else if (last_hs) flt_q <= 1'b0;
      if (cfg_count_all ? any_trig : take) cnt <= cnt + 24'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wcnt <= 2'd0;
    end else if (take) begin
      busy <= 1'b1;
      wcnt <= 2'd0;
    end else if (busy && out_ready) begin
      wcnt <= wcnt + 2'd1;
      if (wcnt == 2'd3) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q    <= '0;
      cnt_q    <= '0;
      size_q   <= '0;
      src_q    <= '0;
      mask_q   <= '0;
      mode_q   <= '0;
      roll_lat <= 1'b0;
      fail_q   <= 1'b0;
      zs_q     <= 1'b0;
    end else if (take) begin
      tag_q    <= tag;
      cnt_q    <= cnt;
      size_q   <= payload_len + HDR_LEN;
      src_q    <= {trig_sw, trig_ext, trig_self};
      mask_q   <= ch_mask;
      mode_q   <= cfg_mode;
      roll_lat <= roll_q;
      fail_q   <= flt_q | hw_fault;
      zs_q     <= cfg_zs_en;
    end
  end

  always_comb begin
    case (mode_q)
      2'b01:   field = {5'd0, src_q[5], src_q[4], 5'd0, src_q[3:0]};
      2'b10:   field = tag_q[47:32];
      default: field = 16'd0;
    endcase
  end

  assign w4 = (mode_q == 2'b10) ? tag_q[31:0] : {roll_lat, tag_q[30:0]};

  always_comb begin
    case (wcnt)
      2'd0:    out_data = {MARKER, size_q};
      2'd1:    out_data = {5'd0, fail_q, 1'b0, zs_q, field, 4'd0, mask_q};
      2'd2:    out_data = {8'd0, cnt_q};
      default: out_data = w4;
    endcase
  end

  assign out_valid = busy;
endmodule

// File: rtl/evt_header_framer_chk.sv
module evt_header_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        trig_sw,
  input logic        trig_ext,
  input logic [3:0]  trig_self,
  input logic        evt_accept,
  input logic        cfg_count_all,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic [1:0]  wcnt,
  input logic [1:0]  mode_q,
  input logic [23:0] cnt
);
  wire trig_any = trig_sw | trig_ext | (|trig_self);

  // R1
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R1
  start_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept && trig_any && !out_valid |=> out_valid && wcnt == 2'd0);

  // R10
  no_early_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(out_ready && wcnt == 2'd3) |=> out_valid);

  // R2
  marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && wcnt == 2'd0 |-> out_data[31:28] == 4'b1010);

  // R4
  w2_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && wcnt == 2'd1 |-> out_data[31:27] == 5'd0 && !out_data[25] && out_data[7:4] == 4'd0);

  // R5
  mode_off_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && wcnt == 2'd1 && (mode_q == 2'b00 || mode_q == 2'b11) |-> out_data[23:8] == 16'd0);

  // R6
  count_all_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_count_all && trig_any |=> cnt == $past(cnt) + 24'd1);

  // R6
  count_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_any |=> $stable(cnt));
endmodule

bind evt_header_framer evt_header_framer_chk u_chk (.*);

// File: tb/evt_header_framer_tb.sv
`timescale 1ns/1ps
module evt_header_framer_tb;
  localparam logic [47:0] TAG_INIT = 48'h0001_7FFF_F000;
  localparam logic [23:0] CNT_INIT = 24'hFFFF80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_sw = 0, trig_ext = 0, evt_accept = 0, hw_fault = 0;
  logic [3:0]  trig_self = 0, ch_mask = 0;
  logic [27:0] payload_len = 0;
  logic [1:0]  cfg_mode = 0;
  logic        cfg_count_all = 0, cfg_zs_en = 0, out_ready = 0;
  logic        out_valid;
  logic [31:0] out_data;

  always #2.5 clk = ~clk;

  evt_header_framer #(.TAG_INIT(TAG_INIT), .CNT_INIT(CNT_INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_sw(trig_sw), .trig_ext(trig_ext),
    .trig_self(trig_self), .evt_accept(evt_accept), .hw_fault(hw_fault),
    .ch_mask(ch_mask), .payload_len(payload_len), .cfg_mode(cfg_mode),
    .cfg_count_all(cfg_count_all), .cfg_zs_en(cfg_zs_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  int checks = 0, fails = 0;
  logic [47:0] m_tag, t_done;
  logic [23:0] m_cnt;
  logic        m_flt;
  logic [31:0] expw [4];
  int          widx = 4;
  logic        chk_hold = 0, chk_idle = 0;
  logic [31:0] hold_d;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] field_of(input logic [1:0] md, input logic sw, input logic ex,
                                           input logic [3:0] sf, input logic [47:0] tg);
    case (md)
      2'b01:   return {5'd0, sw, ex, 5'd0, sf};
      2'b10:   return tg[47:32];
      default: return 16'd0;
    endcase
  endfunction

  task automatic cycle();
    logic v, hs, acc, anyt, last;
    logic [31:0] d;
    v = out_valid; d = out_data;
    if (chk_hold) begin
      chk(v == 1'b1, "R1 valid held", {31'd0, v}, 32'd1);
      chk(d == hold_d, "R1 data held", d, hold_d);
    end
    if (chk_idle) chk(v == 1'b0, "R10 accept while busy ignored", {31'd0, v}, 32'd0);
    chk_hold = v && !out_ready;
    hold_d = d;
    hs = v && out_ready;
    last = 0;
    chk_idle = 0;
    if (hs) begin
      case (widx)
        0: chk(d == expw[0], "R2 word1", d, expw[0]);
        1: begin
          chk(d[26] == expw[1][26], "R3 fail flag", {31'd0, d[26]}, {31'd0, expw[1][26]});
          chk({d[31:27], d[25:24], d[7:0]} == {expw[1][31:27], expw[1][25:24], expw[1][7:0]},
              "R4 word2 fixed fields", d, expw[1]);
          chk(d[23:8] == expw[1][23:8], "R5 mode field", {16'd0, d[23:8]}, {16'd0, expw[1][23:8]});
        end
        2: chk(d == expw[2], "R6 R7 word3 counter", d, expw[2]);
        default: begin
          chk(d[30:0] == expw[3][30:0], "R8 word4 tag", d, expw[3]);
          chk(d[31] == expw[3][31], "R8 R9 word4 msb", {31'd0, d[31]}, {31'd0, expw[3][31]});
        end
      endcase
      if (widx == 3) begin
        last = 1;
        t_done = m_tag;
        chk_idle = 1;
      end
      widx++;
    end else if (v && widx > 3) begin
      chk(1'b0, "R10 extra word", d, 32'd0);
    end
    anyt = trig_sw | trig_ext | (|trig_self);
    acc = evt_accept && anyt && !v;
    if (acc) begin
      expw[0] = {4'b1010, payload_len + 28'd4};
      expw[1] = {5'd0, m_flt | hw_fault, 1'b0, cfg_zs_en,
                 field_of(cfg_mode, trig_sw, trig_ext, trig_self, m_tag), 4'd0, ch_mask};
      expw[2] = {8'd0, m_cnt};
      expw[3] = (cfg_mode == 2'b10) ? m_tag[31:0]
              : {(m_tag >> 31) != (t_done >> 31), m_tag[30:0]};
      widx = 0;
      chk_idle = 0;
    end
    if (cfg_count_all ? anyt : acc) m_cnt = m_cnt + 24'd1;
    if (last) m_flt = hw_fault;
    else      m_flt = m_flt | hw_fault;
    m_tag = m_tag + 48'd1;
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    trig_sw = 0; trig_ext = 0; trig_self = 0; evt_accept = 0; hw_fault = 0;
  endtask

  task automatic rand_inputs();
    trig_sw     = ($urandom % 8) == 0;
    trig_ext    = ($urandom % 8) == 0;
    trig_self   = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
    evt_accept  = ($urandom % 2) == 0;
    hw_fault    = ($urandom % 50) == 0;
    out_ready   = ($urandom % 10) < 7;
    ch_mask     = 4'($urandom);
    payload_len = 28'($urandom);
    cfg_mode    = 2'($urandom);
    cfg_zs_en   = 1'($urandom);
    if (($urandom % 64) == 0) cfg_count_all = 1'($urandom);
  endtask

  initial begin
    #750000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R11 valid low in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    m_tag = TAG_INIT; t_done = TAG_INIT; m_cnt = CNT_INIT; m_flt = 0;
    chk(out_valid == 1'b0, "R11 valid low after reset", {31'd0, out_valid}, 32'd0);

    // R9: idle past a 31-bit wrap, then accept with mode 00
    out_ready = 1;
    repeat (4200) begin idle_inputs(); cycle(); end
    idle_inputs(); evt_accept = 1; trig_sw = 1; cfg_mode = 2'b00; payload_len = 28'd10;
    cycle();
    idle_inputs();
    repeat (6) cycle();
    // R5/R8: extended mode, size wrap in R2
    evt_accept = 1; trig_ext = 1; cfg_mode = 2'b10; payload_len = 28'hFFFFFFE; hw_fault = 1;
    cycle();
    idle_inputs();
    repeat (6) cycle();
    // R10: accept with no trigger
    evt_accept = 1; cycle();
    idle_inputs();
    chk(out_valid == 1'b0, "R10 accept without trigger ignored", {31'd0, out_valid}, 32'd0);
    // R6: accepted-only counting, trigger without accept
    cfg_count_all = 0; trig_self = 4'b0101; cycle();
    idle_inputs(); cycle();
    evt_accept = 1; trig_self = 4'b1000; cfg_mode = 2'b01; cycle();
    idle_inputs();
    repeat (6) cycle();
    // mixed random traffic with backpressure
    repeat (20000) begin rand_inputs(); cycle(); end
    idle_inputs(); out_ready = 1;
    repeat (8) cycle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule